// File: doc/BRIEF.md
# Power-of-Two Rate Task Enabler

This block decides, on each pass of a round-robin task loop, which of a fixed number of task slots may run on that pass. The loop controller pulses a tick input once per pass. Each slot holds a small rate code that software loads through a simple write port. The block answers every tick with one enable bit per slot.

The decisions come from one shared pass counter that advances on every tick and wraps. A slot with rate code r runs when the low r bits of that counter are all zero. Code 0 therefore runs the slot on every pass, and codes 1 to 4 run it on one pass in 2, 4, 8 or 16. Any larger code freezes the slot, so it never runs. A synchronous clear input returns the pass counter to its starting point, so that every slot is due again on the next tick.

Top module: `rate_gate_sched`

## Requirements
- R1: After reset every enable output is 0, every slot's rate code is 0 and the pass counter is 0, so the first tick enables every slot.
- R2: A slot with rate code 0 has its enable bit at 1 in the cycle after every tick.
- R3: A slot with rate code r, where r is 1, 2, 3 or 4, has its enable bit at 1 after a tick exactly when the low r bits of the pass count are all zero. The pass count is the number of earlier ticks since the last reset or clear, taken modulo 16.
- R4: A slot whose rate code is 5, 6 or 7 never has its enable bit at 1.
- R5: Enable bits are registered. They are 1 only in the single cycle that follows a tick, and every enable bit is 0 in the cycle after a clock edge with no tick.
- R6: A clear at a clock edge sets the pass count to 0 and drives all enables to 0 in the next cycle. A tick at the same edge is ignored. Rate codes are kept.
- R7: The pass count wraps from 15 to 0, so the 17th tick after a clear enables every slot whose code is 0 to 4 again.
- R8: A write stores wr_code_i into slot wr_slot_i. A tick at the same edge still uses the old code. Other slots are not changed. A write to a slot index of NUM_SLOTS or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the pass counter; takes priority over a tick |
| tick_i | input | 1 | One pulse per loop pass |
| wr_en_i | input | 1 | Rate code write strobe |
| wr_slot_i | input | SLOT_W | Slot index to write |
| wr_code_i | input | CODE_W | Rate code to store |
| run_en_o | output | NUM_SLOTS | Per-slot run enable, valid in the cycle after a tick |

## Verification
The bench builds the block with NUM_SLOTS = 8, CODE_W = 3 and CNT_W = 4. This lets the eight slots hold all eight code values at the same time, so every frozen code and every rate from 1 to 1/16 is observed over one full wrap of the pass counter. Random sequences then mix gapped ticks, clears, and writes that land on a tick edge, including writes to a slot in use. A behavioural model is compared with the outputs on every cycle.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

  // Slot is due when its code is in range and the low `code` bits of the
  // pass count are zero.
  function automatic logic pass_due(input int unsigned code,
                                    input int unsigned count,
                                    input int unsigned max_rate);
    int unsigned mask;
    if (code > max_rate) return 1'b0;
    mask = (32'd1 << code) - 32'd1;
    return ((count & mask) == 32'd0);
  endfunction

  // Next pass count with wrap at 2**width.
  function automatic int unsigned pass_next(input int unsigned count,
                                            input int unsigned width);
    return (count + 32'd1) & ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/rgs_pass_counter.sv
module rgs_pass_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] count_o
);
  import rgs_pkg::*;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (adv_i)   count_q <= CNT_W'(pass_next(32'(count_q), CNT_W));
  end

  assign count_o = count_q;
endmodule

// File: rtl/rgs_code_bank.sv
module rgs_code_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 3,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en_i,
  input  logic [SLOT_W-1:0]                  wr_slot_i,
  input  logic [CODE_W-1:0]                  wr_code_i,
  output logic [NUM_SLOTS-1:0][CODE_W-1:0]   codes_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic             hit;
    logic [CODE_W-1:0] code_q;

    assign hit = wr_en_i && (32'(wr_slot_i) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= '0;
      else if (hit) code_q <= wr_code_i;
    end

    assign codes_o[g] = code_q;
  end
endmodule

// File: rtl/rgs_due_gate.sv
module rgs_due_gate #(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 3,
  parameter int CNT_W     = 4
) (
  input  logic [NUM_SLOTS-1:0][CODE_W-1:0] codes_i,
  input  logic [CNT_W-1:0]                 count_i,
  output logic [NUM_SLOTS-1:0]             due_o
);
  import rgs_pkg::*;

  localparam int MAX_RATE = CNT_W;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_due
    assign due_o[g] = pass_due(32'(codes_i[g]), 32'(count_i), MAX_RATE);
  end
endmodule

// File: rtl/rate_gate_sched.sv
module rate_gate_sched #(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 3,
  parameter int CNT_W     = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic [SLOT_W-1:0]    wr_slot_i,
  input  logic [CODE_W-1:0]    wr_code_i,
  output logic [NUM_SLOTS-1:0] run_en_o
);
  // Named internal events, visible to the bound checker.
  logic                             pass_adv;
  logic [CNT_W-1:0]                 pass_cnt;
  logic [NUM_SLOTS-1:0][CODE_W-1:0] slot_code;
  logic [NUM_SLOTS-1:0]             slot_due;
  logic [NUM_SLOTS-1:0]             run_en_q;

  assign pass_adv = tick_i && !clear_i;

  rgs_pass_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .adv_i   (pass_adv),
    .count_o (pass_cnt)
  );

  rgs_code_bank #(.NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W)) u_codes (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_slot_i (wr_slot_i),
    .wr_code_i (wr_code_i),
    .codes_o   (slot_code)
  );

  rgs_due_gate #(.NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_gate (
    .codes_i (slot_code),
    .count_i (pass_cnt),
    .due_o   (slot_due)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_en_q <= '0;
    else if (pass_adv) run_en_q <= slot_due;
    else               run_en_q <= '0;
  end

  assign run_en_o = run_en_q;
endmodule

// File: rtl/rgs_checker.sv
module rgs_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 3,
  parameter int CNT_W     = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             clear_i,
  input logic                             tick_i,
  input logic [NUM_SLOTS-1:0]             run_en_o,
  input logic [CNT_W-1:0]                 pass_cnt,
  input logic [NUM_SLOTS-1:0][CODE_W-1:0] slot_code
);
  // R5: no tick (or a clear) leaves every enable low next cycle
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i || clear_i) |=> (run_en_o == '0));

  // R6: clear returns the pass counter to zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (pass_cnt == '0));

  // R7: each accepted tick steps the counter by one, wrapping
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clear_i) |=> (pass_cnt == CNT_W'($past(pass_cnt) + 1'b1)));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
    // R2: code 0 runs on every tick
    p_every_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !clear_i && slot_code[g] == '0) |=> run_en_o[g]);

    // R4: out-of-range code never runs
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(slot_code[g]) > CNT_W) |=> !run_en_o[g]);

    // R3: an enabled slot was due at a counter with its low bits clear
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !clear_i && 32'(slot_code[g]) <= CNT_W &&
       ((32'(pass_cnt) & ((32'd1 << slot_code[g]) - 32'd1)) != 0))
      |=> !run_en_o[g]);
  end
endmodule

bind rate_gate_sched rgs_checker #(
  .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear_i   (clear_i),
  .tick_i    (tick_i),
  .run_en_o  (run_en_o),
  .pass_cnt  (pass_cnt),
  .slot_code (slot_code)
);

// File: tb/rate_gate_sched_tb_top.sv
module rate_gate_sched_tb_top;
  localparam int NS  = 8;
  localparam int CW  = 3;
  localparam int KW  = 4;
  localparam int SW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear_i = 1'b0;
  logic          tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [SW-1:0] wr_slot_i = '0;
  logic [CW-1:0] wr_code_i = '0;
  logic [NS-1:0] run_en_o;

  rate_gate_sched #(.NUM_SLOTS(NS), .CODE_W(CW), .CNT_W(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_slot_i(wr_slot_i), .wr_code_i(wr_code_i),
    .run_en_o(run_en_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state
  int m_pass = 0;            // ticks since reset/clear
  int m_code[NS];
  bit m_exp[NS];
  string m_tag[NS];

  function automatic bit due(int code, int pass);
    int period;
    if (code > 4) return 0;
    period = 1 << code;
    return (pass % 16) % period == 0;
  endfunction

  task automatic compare_all();
    for (int s = 0; s < NS; s++) begin
      checks++;
      if (run_en_o[s] !== m_exp[s]) begin
        errors++;
        $display("FAIL %s slot %0d: actual %0b expected %0b", m_tag[s], s,
                 run_en_o[s], m_exp[s]);
      end
    end
  endtask

  // Called at a falling edge: check outputs, drive stimulus, update model.
  task automatic step(bit tk, bit clr, bit we, int slot, int code);
    compare_all();
    tick_i = tk; clear_i = clr; wr_en_i = we;
    wr_slot_i = SW'(slot); wr_code_i = CW'(code);
    for (int s = 0; s < NS; s++) begin
      if (clr) begin
        m_exp[s] = 0; m_tag[s] = "R6";
      end else if (tk) begin
        m_exp[s] = due(m_code[s], m_pass);
        if (m_code[s] > 4)              m_tag[s] = "R4";
        else if (m_code[s] == 0)        m_tag[s] = "R2";
        else if (m_pass >= 16 && m_pass % 16 == 0) m_tag[s] = "R7";
        else                            m_tag[s] = "R3";
      end else begin
        m_exp[s] = 0; m_tag[s] = "R5";
      end
    end
    if (clr)     m_pass = 0;
    else if (tk) m_pass = m_pass + 1;
    if (we && slot < NS) m_code[slot] = code;   // R8: after the decision
    @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_code[s] = 0; m_exp[s] = 0; m_tag[s] = "R1";
    end
    repeat (3) @(negedge clk);
    compare_all();                 // R1: enables low in reset
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first tick after reset enables every slot (codes reset to 0)
    step(1, 0, 0, 0, 0);
    // load codes 0..7 into slots 0..7
    for (int s = 0; s < NS; s++) step(0, 0, 1, s, s);
    step(1, 0, 0, 0, 0);
    // clear so the count restarts, then 40 back-to-back ticks (R3, R7)
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0);
    // gapped ticks (R5)
    for (int i = 0; i < 30; i++) step(i % 3 == 0, 0, 0, 0, 0);
    // clear together with tick: tick ignored (R6)
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    // R8: write on a tick edge; old code 0 used, then frozen code 5
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    step(1, 0, 1, 1, 5);
    checks++;
    if (run_en_o[1] !== 1'b1) begin
      errors++;
      $display("FAIL R8 old code on write edge: actual %0b expected 1", run_en_o[1]);
    end
    step(1, 0, 0, 0, 0);
    checks++;
    if (run_en_o[1] !== 1'b0 || run_en_o[0] !== 1'b1) begin
      errors++;
      $display("FAIL R8 new code / neighbour: actual %0b%0b expected 01",
               run_en_o[1], run_en_o[0]);
    end
    // random mix (R2..R8)
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 60, r >= 97, $urandom_range(0, 9) == 0,
           $urandom_range(0, NS - 1), $urandom_range(0, 7));
    end
    compare_all();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule